// File: doc/BRIEF.md
# UTOPIA Level 2 Receive PHY Port

This block is the PHY-side receive port on a shared UTOPIA Level 2 bus that carries several PHY devices. It stores ATM cells arriving from the line side and hands them to the ATM-layer master one byte per clock. The master drives that clock, and every register in the block runs on it. Each port on the bus has its own 5-bit address. The port answers a poll with a cell-available indication, and it sends a cell only after the master has selected it by address.

Line-side logic loads the internal cell buffer one byte at a time. The port counts a cell as ready only when all 53 of its bytes are stored. On the bus side the port never drives a shared line directly. Each output comes with an enable, and the pad ring turns that enable into a tri-state driver. The enables drop when the port is not addressed or not enabled. A control input, `tri_all_i`, forces every enable low so that a port with a wrong address cannot fight another PHY on the bus.

Top module: `utopia_rx_port`

## Requirements
- R1: After reset, `rx_data_oe_o`, `rx_clav_oe_o` and `rx_soc_o` are 0, and `wr_room_o` is 1.
- R2: The port is selected only when `rx_addr_i` equals `cfg_addr_i` on the clock where `rx_enb_ni` is first sampled low. If the address differs, `rx_data_oe_o` stays 0 for as long as enable stays low.
- R3: Suppose the port is selected and holds a complete cell, and `rx_enb_ni` is sampled low at edge k. Then from edge k until edge k+1, `rx_data_oe_o` is 1 and `rx_data_o` carries the next unread byte. Bytes leave in the order they were written, and each cycle in which enable was low at the previous edge moves to the next byte.
- R4: `rx_soc_o` is 1 exactly on the cycles that present byte index 0 of a cell, and 0 on every other cycle.
- R5: A cell is 53 bytes long. After byte index 52 is accepted, the byte index wraps to 0 and the cell leaves the buffer. If enable stays low and another complete cell is stored, that cell's byte 0 follows with no gap. If no other complete cell is stored, `rx_data_oe_o` drops to 0.
- R6: If `rx_enb_ni` goes high partway through a cell, the byte index holds. When the port is selected again, transfer resumes at the same byte, and `rx_soc_o` stays 0.
- R7: On any cycle that follows an edge where `rx_enb_ni` was sampled high, `rx_data_oe_o` and `rx_soc_o` are 0 and `rx_data_o` reads 0.
- R8: `rx_clav_oe_o` is 1 exactly on the cycle after an edge where `rx_addr_i` equalled `cfg_addr_i`. While it is 1, `rx_clav_o` is 1 if and only if at least one complete cell is stored. The cell being sent counts as stored until its last byte is accepted.
- R9: While `tri_all_i` is 1, `rx_clav_oe_o` is 0 and no transfer starts. The cycle after an edge that samples it high has `rx_data_oe_o` at 0, and no byte is used up.
- R10: The buffer holds 2 cells. `wr_room_o` is 1 while a free cell slot exists. A byte written with `wr_valid_i` when no slot is free and no cell is partly written is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk_i | input | 1 | Byte clock driven by the ATM-layer master |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_enb_ni | input | 1 | Receive enable from the master, active low |
| rx_addr_i | input | 5 | Bus address for polling and selection |
| cfg_addr_i | input | 5 | This port's configured bus address |
| tri_all_i | input | 1 | Control bit: release all bus outputs |
| wr_valid_i | input | 1 | Line-side byte write strobe |
| wr_data_i | input | 8 | Line-side byte |
| wr_room_o | output | 1 | A free cell slot exists |
| rx_data_o | output | 8 | Cell byte toward the master, 0 when not enabled |
| rx_soc_o | output | 1 | Start-of-cell marker |
| rx_data_oe_o | output | 1 | Output enable for the data and start-of-cell lines |
| rx_clav_o | output | 1 | Cell-available value |
| rx_clav_oe_o | output | 1 | Output enable for the cell-available line |

## Verification
The assertions check on every cycle that the byte index changes only on accept cycles and wraps after index 52. They also check that a transfer cycle always follows a sampled-low enable while the quiet bit was clear, that the cell-available line is driven only after a matching poll address, and that the cell count never goes above capacity or below zero. Only the bench scenarios can show the rest: that bytes come out in write order, that the start-of-cell marker lands at the cell boundary both for back-to-back cells and after a pause, and that a wrong select address or a quiet period leaves the byte position untouched. Full sweeps over all 32 addresses, for both polling and selection, confirm that the port answers only its own address.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned CELL_BYTES = 53;
  localparam int unsigned CELLS      = 2;
endpackage

// File: rtl/rx_cell_buf.sv
module rx_cell_buf #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned CELLS      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_room_o,
  input  logic              rd_adv_i,
  input  logic              rd_pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              cell_any_o,
  output logic              avail_o
);
  localparam int unsigned DEPTH = CELL_BYTES * CELLS;
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned IDX_W = $clog2(CELL_BYTES);
  localparam int unsigned CNT_W = $clog2(CELLS + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [IDX_W-1:0]  wr_idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              partial, accept, push_done;

  assign partial   = (wr_idx_q != '0);
  assign accept    = wr_valid_i & (partial | (cnt_q < CNT_W'(CELLS)));
  assign push_done = accept & (wr_idx_q == IDX_W'(CELL_BYTES - 1));

  assign wr_room_o  = (cnt_q + CNT_W'(partial)) < CNT_W'(CELLS);
  assign rd_data_o  = mem[rd_ptr_q];
  assign cell_any_o = (cnt_q != '0);
  // availability seen after this cycle's pop; a concurrent push is ignored
  assign avail_o    = rd_pop_i ? (cnt_q > CNT_W'(1)) : (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (accept) mem[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      wr_idx_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (accept) begin
        wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
        wr_idx_q <= push_done ? '0 : wr_idx_q + 1'b1;
      end
      if (rd_adv_i)
        rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_done) - CNT_W'(rd_pop_i);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CELLS)); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pop_i |-> cnt_q != '0); // R5
  AST_DROP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !partial && cnt_q == CNT_W'(CELLS)) |=> $stable(wr_ptr_q)); // R10
endmodule

// File: rtl/rx_bus_ctl.sv
module rx_bus_ctl #(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned CELL_BYTES = 53
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enb_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              quiet_i,
  input  logic              avail_i,
  output logic              xfer_o,
  output logic              soc_o,
  output logic              pop_o,
  output logic              poll_hit_o
);
  localparam int unsigned IDX_W = $clog2(CELL_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CELL_BYTES - 1);

  logic             enb_prev_q, sel_q, xfer_q, poll_q;
  logic [IDX_W-1:0] idx_q;
  logic             enb_act, addr_hit, sel_d;

  assign enb_act  = ~enb_ni;
  assign addr_hit = (addr_i == cfg_addr_i);
  // selection is latched only on the falling edge of enable
  assign sel_d    = (enb_act & ~enb_prev_q) ? addr_hit : sel_q;

  assign xfer_o     = xfer_q;
  assign soc_o      = xfer_q & (idx_q == '0);
  assign pop_o      = xfer_q & (idx_q == LAST);
  assign poll_hit_o = poll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enb_prev_q <= 1'b0;
      sel_q      <= 1'b0;
      xfer_q     <= 1'b0;
      poll_q     <= 1'b0;
      idx_q      <= '0;
    end else begin
      enb_prev_q <= enb_act;
      sel_q      <= sel_d;
      xfer_q     <= enb_act & sel_d & avail_i & ~quiet_i;
      poll_q     <= addr_hit;
      if (xfer_q) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
  end

  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_q |=> $stable(idx_q)); // R6
  AST_IDX_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_q && idx_q == LAST) |=> idx_q == '0); // R5
  AST_XFER_AFTER_ENB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_q |-> $past(!enb_ni)); // R7
  AST_QUIET_NO_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_q |-> $past(!quiet_i)); // R9
endmodule

// File: rtl/utopia_rx_port.sv
module utopia_rx_port
  import utopia_rx_pkg::*;
#(
  parameter int unsigned P_DATA_W     = DATA_W,
  parameter int unsigned P_ADDR_W     = ADDR_W,
  parameter int unsigned P_CELL_BYTES = CELL_BYTES,
  parameter int unsigned P_CELLS      = CELLS
) (
  input  logic                rx_clk_i,
  input  logic                rst_ni,
  input  logic                rx_enb_ni,
  input  logic [P_ADDR_W-1:0] rx_addr_i,
  input  logic [P_ADDR_W-1:0] cfg_addr_i,
  input  logic                tri_all_i,
  input  logic                wr_valid_i,
  input  logic [P_DATA_W-1:0] wr_data_i,
  output logic                wr_room_o,
  output logic [P_DATA_W-1:0] rx_data_o,
  output logic                rx_soc_o,
  output logic                rx_data_oe_o,
  output logic                rx_clav_o,
  output logic                rx_clav_oe_o
);
  logic                xfer, soc, pop, poll_hit, cell_any, avail;
  logic [P_DATA_W-1:0] rd_data;

  rx_cell_buf #(
    .DATA_W(P_DATA_W), .CELL_BYTES(P_CELL_BYTES), .CELLS(P_CELLS)
  ) i_buf (
    .clk_i(rx_clk_i), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_room_o(wr_room_o),
    .rd_adv_i(xfer), .rd_pop_i(pop), .rd_data_o(rd_data),
    .cell_any_o(cell_any), .avail_o(avail)
  );

  rx_bus_ctl #(
    .ADDR_W(P_ADDR_W), .CELL_BYTES(P_CELL_BYTES)
  ) i_ctl (
    .clk_i(rx_clk_i), .rst_ni(rst_ni),
    .enb_ni(rx_enb_ni), .addr_i(rx_addr_i), .cfg_addr_i(cfg_addr_i),
    .quiet_i(tri_all_i), .avail_i(avail),
    .xfer_o(xfer), .soc_o(soc), .pop_o(pop), .poll_hit_o(poll_hit)
  );

  assign rx_data_oe_o = xfer;
  assign rx_data_o    = xfer ? rd_data : '0;
  assign rx_soc_o     = soc;
  assign rx_clav_oe_o = poll_hit & ~tri_all_i;
  assign rx_clav_o    = cell_any & rx_clav_oe_o;

  AST_CLAV_POLLED: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    rx_clav_oe_o |-> $past(rx_addr_i == cfg_addr_i)); // R8
  AST_DATA_AFTER_ENB: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    $past(rx_enb_ni) |-> !rx_data_oe_o && !rx_soc_o); // R7
endmodule

// File: tb/test_utopia_rx_port.sv
module test_utopia_rx_port;
  logic       clk = 1'b0;
  logic       rst_ni, enb_n, tri_all, wr_valid, wr_room;
  logic [4:0] addr;
  logic [7:0] wr_data, data;
  logic       soc, data_oe, clav, clav_oe;

  localparam logic [4:0] CFG = 5'd9;
  localparam int         CB  = 53;

  int  checks = 0, errors = 0;
  int  wser = 0, rser = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  utopia_rx_port i_utopia_rx_port (
    .rx_clk_i(clk), .rst_ni(rst_ni), .rx_enb_ni(enb_n), .rx_addr_i(addr),
    .cfg_addr_i(CFG), .tri_all_i(tri_all), .wr_valid_i(wr_valid),
    .wr_data_i(wr_data), .wr_room_o(wr_room), .rx_data_o(data),
    .rx_soc_o(soc), .rx_data_oe_o(data_oe), .rx_clav_o(clav),
    .rx_clav_oe_o(clav_oe)
  );

  function automatic logic [7:0] pat(int s);
    return 8'((s * 37 + 11) & 255);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic write_cells(int n);
    for (int i = 0; i < n * CB; i++) begin
      wr_valid = 1'b1; wr_data = pat(wser); wser++;
      tick();
    end
    wr_valid = 1'b0;
  endtask

  task automatic read_bytes(string r, int n);
    for (int i = 0; i < n; i++) begin
      tick();
      chk({r, " R3 oe"}, 32'(data_oe), 1);
      chk({r, " R3 data"}, 32'(data), 32'(pat(rser)));
      chk({r, " R4 soc"}, 32'(soc), 32'((rser % CB) == 0));
      rser++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; enb_n = 1'b1; addr = '0; tri_all = 1'b0;
    wr_valid = 1'b0; wr_data = '0;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 data_oe", 32'(data_oe), 0);
    chk("R1 clav_oe", 32'(clav_oe), 0);
    chk("R1 soc", 32'(soc), 0);
    chk("R1 room", 32'(wr_room), 1);

    write_cells(2);
    chk("R10 full room", 32'(wr_room), 0);
    for (int i = 0; i < CB; i++) begin
      wr_valid = 1'b1; wr_data = 8'hEE;
      tick();
    end
    wr_valid = 1'b0;

    addr = CFG; tick();
    chk("R8 clav_oe hit", 32'(clav_oe), 1);
    chk("R8 clav value", 32'(clav), 1);
    addr = 5'd4; tick();
    chk("R8 clav_oe miss", 32'(clav_oe), 0);

    addr = 5'd3; enb_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R2 wrong addr", 32'(data_oe), 0);
    end
    enb_n = 1'b1; tick();

    addr = CFG; enb_n = 1'b0;
    read_bytes("R3", 1);
    addr = 5'd17;
    read_bytes("R2 held", 19);

    enb_n = 1'b1;
    for (int i = 0; i < 2; i++) begin
      tick();
      chk("R7 oe", 32'(data_oe), 0);
      chk("R7 data", 32'(data), 0);
      chk("R7 soc", 32'(soc), 0);
    end

    tri_all = 1'b1; addr = CFG; enb_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R9 data_oe", 32'(data_oe), 0);
      chk("R9 clav_oe", 32'(clav_oe), 0);
    end
    tri_all = 1'b0; enb_n = 1'b1; tick();
    chk("R8 clav_oe after quiet", 32'(clav_oe), 1);

    enb_n = 1'b0;
    read_bytes("R6 resume", 1);
    read_bytes("R5 wrap", 2 * CB - 21);
    tick();
    chk("R5 empty oe", 32'(data_oe), 0);
    chk("R10 room back", 32'(wr_room), 1);
    chk("R8 clav empty", 32'(clav), 0);
    chk("R10 dropped cell", 32'(clav_oe), 1);
    enb_n = 1'b1; tick();

    write_cells(1);
    for (int a = 0; a < 32; a++) begin
      addr = 5'(a); tick();
      chk("R8 sweep oe", 32'(clav_oe), 32'(a == int'(CFG)));
      chk("R8 sweep clav", 32'(clav), 32'(a == int'(CFG)));
    end

    for (int a = 0; a < 32; a++) begin
      enb_n = 1'b1; addr = 5'(a); tick();
      enb_n = 1'b0; tick();
      chk("R2 sweep", 32'(data_oe), 32'(a == int'(CFG)));
      if (a == int'(CFG)) begin
        chk("R3 sweep data", 32'(data), 32'(pat(rser)));
        chk("R4 sweep soc", 32'(soc), 1);
        rser++;
      end
    end
    enb_n = 1'b1; tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule